// File: doc/BRIEF.md
# Audio capture slot pair packer

This block sits behind the receive side of an AC-link and turns left and right PCM capture samples into stereo words for a capture FIFO. Each frame it sees a tag word, strobed once, and up to two payload slots, the left slot (slot 3) and the right slot (slot 4), each with its own strobe. A payload is accepted only when the most recently latched tag marks both the frame and that slot as valid. Each accepted 20-bit payload is cut to a 16-bit sample.

Pairing follows arrival order only. The first accepted sample is held. The next accepted sample completes a 32-bit entry, whichever slot it came from and whichever frame it arrived in. A codec that sends the left slot in one frame and the right slot in the next therefore still yields correct pairs. A codec that repeats a slot shifts every later pair, and the block flags no error. A completed pair is written on a one-cycle write strobe unless the FIFO reports full. In that case the pair is lost and a sticky overflow flag is raised. A disable input drops any held half-sample.

Top module: `ac_pcm_in_packer`

## Requirements
- R1: After reset, the write strobe and the overflow flag are low and no half-sample is held.
- R2: A tag strobe latches the tag word, and the latched tag applies to payload strobes in later cycles. A left payload is accepted only if latched tag bits 15 and 12 are both 1. A right payload is accepted only if latched tag bits 15 and 11 are both 1. Payloads that are not accepted have no effect.
- R3: An accepted payload keeps bits 19:4 as its 16-bit sample, and bits 3:0 are dropped.
- R4: The first accepted sample is placed in write data bits 15:0, and the next accepted sample in bits 31:16. The write strobe pulses for one cycle in the cycle after the strobe that completed the pair.
- R5: A held half-sample survives later tag strobes, so a pair may span frames.
- R6: Slot identity is ignored. Two left payloads accepted in a row form one entry, and the following right sample starts a new pair.
- R7: When both payload strobes are accepted in the same cycle, the left sample is taken before the right one.
- R8: If the FIFO full input is high in the cycle a pair completes, no write occurs, the pair is discarded, and the overflow flag is high from the next cycle on.
- R9: The overflow flag stays high until a clear pulse arrives. A clear in the same cycle as a new drop leaves the flag set.
- R10: While the disable input is high, payloads are ignored and any held half-sample is discarded.
- R11: No write happens in the cycle after a cycle with no payload strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_dis_i | input | 1 | Channel disable; flushes the held half-sample |
| tag_vld_i | input | 1 | Tag word strobe |
| tag_i | input | 16 | Frame tag word with valid bits |
| slot_l_vld_i | input | 1 | Left payload strobe |
| slot_l_i | input | 20 | Left payload |
| slot_r_vld_i | input | 1 | Right payload strobe |
| slot_r_i | input | 20 | Right payload |
| fifo_full_i | input | 1 | Capture FIFO full |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | Stereo entry: first sample low, second sample high |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The pairing logic is driven in several ways. Left and right arrive in the same frame and in the same cycle, which shows that the left sample is taken first. Left arrives in one frame and right in the next, which shows that the held half-sample survives a tag update. A left slot is repeated, which shows that pairing follows arrival order and not slot identity. Tags with the frame bit or a slot bit cleared show that payload gating works. Random frames mix in FIFO full, overflow clears and disables, and a bench model predicts every write and flag value.

// File: rtl/ac_pack_pkg.sv
package ac_pack_pkg;
  localparam int TAG_W_D     = 16;
  localparam int SLOT_W_D    = 20;
  localparam int SAMP_W_D    = 16;
  localparam int FRAME_BIT_D = 15;
  localparam int L_BIT_D     = 12;
  localparam int R_BIT_D     = 11;
  localparam int LANES       = 2;  // lane 0 = left, taken first
endpackage

// File: rtl/ac_slot_gate.sv
module ac_slot_gate
  import ac_pack_pkg::*;
#(
  parameter int TAG_W     = TAG_W_D,
  parameter int SLOT_W    = SLOT_W_D,
  parameter int SAMP_W    = SAMP_W_D,
  parameter int FRAME_BIT = FRAME_BIT_D,
  parameter int L_BIT     = L_BIT_D,
  parameter int R_BIT     = R_BIT_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_dis_i,
  input  logic              tag_vld_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LANES-1:0]  vld_i,
  input  logic [SLOT_W-1:0] slot_i [LANES],
  output logic [LANES-1:0]  acc_o,
  output logic [SAMP_W-1:0] samp_o [LANES]
);
  localparam int DROP_W = SLOT_W - SAMP_W;
  localparam int LANE_BIT [LANES] = '{L_BIT, R_BIT};

  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tag_q <= '0;
    else if (tag_vld_i) tag_q <= tag_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc_o[g]  = vld_i[g] & ~chan_dis_i & tag_q[FRAME_BIT] & tag_q[LANE_BIT[g]];
    assign samp_o[g] = slot_i[g][SLOT_W-1:DROP_W];
  end
endmodule

// File: rtl/ac_pair_unit.sv
module ac_pair_unit
  import ac_pack_pkg::*;
#(
  parameter int SAMP_W = SAMP_W_D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chan_dis_i,
  input  logic [LANES-1:0]    acc_i,
  input  logic [SAMP_W-1:0]   samp_i [LANES],
  input  logic                fifo_full_i,
  output logic                wr_o,
  output logic [2*SAMP_W-1:0] wdata_o,
  output logic                drop_o
);
  logic                pend_q, pend_n;
  logic [SAMP_W-1:0]   held_q, held_n;
  logic                done;
  logic [2*SAMP_W-1:0] pair;
  logic                wr_q;
  logic [2*SAMP_W-1:0] wdata_q;

  // Arrival order only: slot identity is not tracked.
  always_comb begin
    pend_n = pend_q;
    held_n = held_q;
    done   = 1'b0;
    pair   = '0;
    if (chan_dis_i) begin
      pend_n = 1'b0;
      held_n = '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (acc_i[i]) begin
          if (pend_n) begin
            pair   = {samp_i[i], held_n};
            done   = 1'b1;
            pend_n = 1'b0;
          end else begin
            held_n = samp_i[i];
            pend_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      held_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      pend_q <= pend_n;
      held_q <= held_n;
      wr_q   <= done & ~fifo_full_i;
      if (done & ~fifo_full_i) wdata_q <= pair;
    end
  end

  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
  assign drop_o  = done & fifo_full_i;
endmodule

// File: rtl/ac_ovf_flag.sv
module ac_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic ovf_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (drop_i) ovf_q <= 1'b1;  // set wins over clear
    else if (clr_i)  ovf_q <= 1'b0;
  end
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ac_pcm_in_packer.sv
module ac_pcm_in_packer
  import ac_pack_pkg::*;
#(
  parameter int TAG_W     = TAG_W_D,
  parameter int SLOT_W    = SLOT_W_D,
  parameter int SAMP_W    = SAMP_W_D,
  parameter int FRAME_BIT = FRAME_BIT_D,
  parameter int L_BIT     = L_BIT_D,
  parameter int R_BIT     = R_BIT_D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chan_dis_i,
  input  logic                tag_vld_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic                slot_l_vld_i,
  input  logic [SLOT_W-1:0]   slot_l_i,
  input  logic                slot_r_vld_i,
  input  logic [SLOT_W-1:0]   slot_r_i,
  input  logic                fifo_full_i,
  input  logic                ovf_clr_i,
  output logic                fifo_wr_o,
  output logic [2*SAMP_W-1:0] fifo_wdata_o,
  output logic                ovf_o
);
  logic [LANES-1:0]  vld, acc;
  logic [SLOT_W-1:0] slot [LANES];
  logic [SAMP_W-1:0] samp [LANES];
  logic              drop;

  assign vld     = {slot_r_vld_i, slot_l_vld_i};
  assign slot[0] = slot_l_i;
  assign slot[1] = slot_r_i;

  ac_slot_gate #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SAMP_W(SAMP_W),
    .FRAME_BIT(FRAME_BIT), .L_BIT(L_BIT), .R_BIT(R_BIT)
  ) i_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_dis_i(chan_dis_i),
    .tag_vld_i(tag_vld_i), .tag_i(tag_i),
    .vld_i(vld), .slot_i(slot), .acc_o(acc), .samp_o(samp)
  );

  ac_pair_unit #(.SAMP_W(SAMP_W)) i_pair (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_dis_i(chan_dis_i),
    .acc_i(acc), .samp_i(samp), .fifo_full_i(fifo_full_i),
    .wr_o(fifo_wr_o), .wdata_o(fifo_wdata_o), .drop_o(drop)
  );

  ac_ovf_flag i_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .drop_i(drop),
    .clr_i(ovf_clr_i), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/ac_pcm_in_packer_chk.sv
module ac_pcm_in_packer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic chan_dis_i,
  input logic slot_l_vld_i,
  input logic slot_r_vld_i,
  input logic fifo_full_i,
  input logic ovf_clr_i,
  input logic fifo_wr_o,
  input logic ovf_o
);
  assert_no_write_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !$past(fifo_full_i));

  assert_ovf_needs_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(fifo_full_i));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  assert_dis_blocks_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_dis_i |=> !fifo_wr_o);

  assert_write_needs_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_l_vld_i && !slot_r_vld_i) |=> !fifo_wr_o);
endmodule

bind ac_pcm_in_packer ac_pcm_in_packer_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chan_dis_i(chan_dis_i),
  .slot_l_vld_i(slot_l_vld_i), .slot_r_vld_i(slot_r_vld_i),
  .fifo_full_i(fifo_full_i), .ovf_clr_i(ovf_clr_i),
  .fifo_wr_o(fifo_wr_o), .ovf_o(ovf_o)
);

// File: tb/test_ac_pcm_in_packer.sv
`timescale 1ns/1ps
module test_ac_pcm_in_packer;
  localparam logic [15:0] T_LR  = 16'h9800;
  localparam logic [15:0] T_L   = 16'h9000;
  localparam logic [15:0] T_R   = 16'h8800;
  localparam logic [15:0] T_NOF = 16'h1800;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic chan_dis_i = 0, tag_vld_i = 0, slot_l_vld_i = 0, slot_r_vld_i = 0;
  logic fifo_full_i = 0, ovf_clr_i = 0;
  logic [15:0] tag_i = '0;
  logic [19:0] slot_l_i = '0, slot_r_i = '0;
  logic fifo_wr_o, ovf_o;
  logic [31:0] fifo_wdata_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  logic [15:0] m_tag = '0, m_held = '0;
  logic        m_pend = 0, e_wr = 0, e_ovf = 0;
  logic [31:0] e_data = '0;

  always #2 clk_i = ~clk_i;

  ac_pcm_in_packer i_ac_pcm_in_packer (.*);

  function automatic logic [15:0] cut(input logic [19:0] s);
    return s[19:4];  // R3
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic tv, input logic [15:0] tg, input logic lv, input logic [19:0] l,
                       input logic rv, input logic [19:0] r, input logic full, input logic clr,
                       input logic dis);
    logic done;
    logic [31:0] pair;
    logic [15:0] s [2];
    logic a [2];
    done = 0; pair = '0;
    a[0] = lv && m_tag[15] && m_tag[12];  // R2
    a[1] = rv && m_tag[15] && m_tag[11];
    s[0] = cut(l); s[1] = cut(r);
    if (dis) begin m_pend = 0; m_held = '0; end  // R10
    else for (int i = 0; i < 2; i++) if (a[i]) begin  // R7 left first
      if (m_pend) begin pair = {s[i], m_held}; done = 1; m_pend = 0; end
      else begin m_held = s[i]; m_pend = 1; end
    end
    e_wr = done && !full;
    if (e_wr) e_data = pair;
    if (done && full) e_ovf = 1;  // R8
    else if (clr) e_ovf = 0;      // R9
    if (tv) m_tag = tg;
  endtask

  task automatic cyc(input logic tv, input logic [15:0] tg, input logic lv, input logic [19:0] l,
                     input logic rv, input logic [19:0] r, input logic full = 0,
                     input logic clr = 0, input logic dis = 0);
    @(negedge clk_i);
    chk(cur_req, {31'd0, fifo_wr_o}, {31'd0, e_wr});
    if (e_wr) chk(cur_req, fifo_wdata_o, e_data);
    chk(cur_req, {31'd0, ovf_o}, {31'd0, e_ovf});
    tag_vld_i = tv; tag_i = tg; slot_l_vld_i = lv; slot_l_i = l;
    slot_r_vld_i = rv; slot_r_i = r; fifo_full_i = full; ovf_clr_i = clr; chan_dis_i = dis;
    model(tv, tg, lv, l, rv, r, full, clr, dis);
  endtask

  task automatic idle(input int n = 1);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";
    idle(2);
    // R2: frame bit clear, then slot bit clear
    cur_req = "R2";
    cyc(1, T_NOF, 0, '0, 0, '0);
    cyc(0, '0, 1, 20'h11111, 1, 20'h22222);
    cyc(1, T_R, 1, 20'h33333, 0, '0);
    cyc(0, '0, 1, 20'h44444, 0, '0);
    cyc(0, '0, 0, '0, 1, 20'h55555);
    cyc(1, T_L, 0, '0, 0, '0);
    cyc(0, '0, 1, 20'h66666, 0, '0);
    idle(2);
    // R3, R4: left then right in one frame
    cur_req = "R3";
    cyc(1, T_LR, 0, '0, 0, '0);
    cyc(0, '0, 1, 20'hABCDE, 0, '0);
    cyc(0, '0, 0, '0, 1, 20'h1234F);
    cur_req = "R4";
    idle(2);
    // R5: pair across frames
    cur_req = "R5";
    cyc(1, T_L, 1, 20'h7777A, 0, '0);
    cyc(0, '0, 1, 20'h8888B, 0, '0);
    cyc(1, T_R, 0, '0, 0, '0);
    cyc(0, '0, 0, '0, 1, 20'h9999C, 0, 0, 0);
    idle(2);
    // R6: repeated left shifts pairing
    cur_req = "R6";
    cyc(1, T_LR, 0, '0, 0, '0);
    cyc(0, '0, 1, 20'h00010, 0, '0);
    cyc(0, '0, 1, 20'h00020, 0, '0);
    cyc(0, '0, 0, '0, 1, 20'h00030);
    cyc(0, '0, 1, 20'h00040, 0, '0);
    idle(2);
    // R7: both strobes in one cycle, with and without a held half
    cur_req = "R7";
    cyc(0, '0, 1, 20'hAAAA0, 1, 20'hBBBB0);
    cyc(0, '0, 1, 20'hCCCC0, 0, '0);
    cyc(0, '0, 1, 20'hDDDD0, 1, 20'hEEEE0);
    cyc(0, '0, 0, '0, 1, 20'hFFFF0);
    idle(2);
    // R8, R9: full drop, sticky, set wins over clear
    cur_req = "R8";
    cyc(0, '0, 1, 20'h12340, 1, 20'h56780, 1);
    idle(3);
    cur_req = "R9";
    cyc(0, '0, 1, 20'h1, 1, 20'h2, 1, 1);
    idle(2);
    cyc(0, '0, 0, '0, 0, '0, 0, 1);
    idle(2);
    // R10: disable flushes a held half
    cur_req = "R10";
    cyc(0, '0, 1, 20'h31410, 0, '0);
    cyc(0, '0, 0, '0, 0, '0, 0, 0, 1);
    cyc(0, '0, 1, 20'h27180, 1, 20'h16180, 0, 0, 1);
    cyc(0, '0, 0, '0, 1, 20'h14140);
    cyc(0, '0, 0, '0, 1, 20'h17320);
    idle(2);
    // Random frames: R4, R11 and mixes of all the above
    cur_req = "R4";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] tg;
      tg = {$urandom_range(0, 7) != 0 ? 1'b1 : 1'b0, 2'b00,
            $urandom_range(0, 5) != 0 ? 1'b1 : 1'b0,
            $urandom_range(0, 5) != 0 ? 1'b1 : 1'b0, 11'($urandom)};
      cyc($urandom_range(0, 3) == 0, tg,
          $urandom_range(0, 2) == 0, 20'($urandom),
          $urandom_range(0, 2) == 0, 20'($urandom),
          $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 40) == 0);
    end
    cur_req = "R11";
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule